// File: doc/BRIEF.md
# Address-Scanned Keyboard Matrix Port

This block is a read-only port in memory space that lets a processor scan a key matrix without first writing a column register. During a read, the low eight address bits act as column drive lines. Each set bit drives one matrix column. The port returns the state of the eight row lines on its data output. The block decodes a 1 KB window. Within that window, firmware chooses which columns to look at by choosing the offset it reads. A read at offset 0x01 looks at column 0, and a read at offset 0x80 looks at column 7. An offset with several bits set looks at several columns together.

The key matrix state comes in already debounced, as one bit per key. Each row line is modelled as a pulled-up line. A pressed key in any driven column pulls its row line low. The port inverts the row lines, so a pressed key reads back as 1.

A small two-state sequencer registers the result:
- **ST_IDLE**: the output enable is low and the data is zero.
- **ST_ACTIVE**: the output carries the scan result for the access seen on the previous edge.
- **Transitions**: *GO_ACTIVE* moves from ST_IDLE to ST_ACTIVE when a qualified read appears. *STAY_ACTIVE* holds ST_ACTIVE while the read continues. *GO_IDLE* returns to ST_IDLE when the read ends.

Top module: `kbd_scan_port`

## Requirements
- R1: While reset is held, and on the first edge after reset is released with no access present, rd_oe is 0 and rd_data is 0.
- R2: An access is qualified when kbd_cs=1, cpu_rd=1 and cpu_addr[15:10]=6'b111101 (window 0xF400–0xF7FF). On the edge after a qualified access, rd_oe is 1.
- R3: On the edge after a cycle with no qualified access, rd_oe is 0 and rd_data is 0. This holds even when kbd_cs and cpu_rd are both 1 but the address is outside the window.
- R4: Bit c*8+r of key_state is 1 when the key at column c and row r is pressed. With exactly one column bit cpu_addr[c] set, rd_data[r] is 1 exactly when key (c,r) is pressed.
- R5: With several column bits set, rd_data[r] is 1 when any selected column has a pressed key on row r. This is the wired-AND of the active-low row lines, read inverted.
- R6: A qualified access with cpu_addr[7:0]=0 returns rd_data=0 whatever keys are pressed.
- R7: Address bits cpu_addr[9:8] have no effect on rd_data.
- R8: During a sustained access, rd_data follows changes to the address and to key_state with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address; bits 7:0 select columns |
| cpu_rd | input | 1 | Read strobe |
| kbd_cs | input | 1 | Chip-select from the memory decoder |
| key_state | input | 64 | Debounced key matrix, bit c*8+r = key at column c, row r, 1 = pressed |
| rd_data | output | 8 | Row result, 1 = pressed key in a selected column |
| rd_oe | output | 1 | High while the port drives the data bus |

## Verification
The assertions check the following on every cycle:
- The output stays quiet after any cycle without a qualified read.
- The enable rises after a qualified read.
- An empty column selection reads zero, and an idle matrix reads zero.
- Non-zero data never appears without the enable.

The exact mapping from a key's column and row to a data bit is shown only by the bench's scenarios. So are the OR across several driven columns, the indifference to address bits 9:8, and the one-cycle tracking of address and key changes. The bench compares all of these against its behavioural model on every clock.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int KBD_ADDR_W   = 16;
    localparam int KBD_COLS     = 8;
    localparam int KBD_ROWS     = 8;
    localparam int KBD_WIN_BITS = 10;
    localparam logic [KBD_ADDR_W-1:0] KBD_WIN_BASE = 16'hF400;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } kbd_acc_state_e;
endpackage

// File: rtl/kbd_col_driver.sv
module kbd_col_driver #(
    parameter int NUM_COLS = 8,
    parameter int NUM_ROWS = 8
) (
    input  logic [NUM_COLS-1:0]          col_sel,
    input  logic [NUM_COLS*NUM_ROWS-1:0] key_state,
    output logic [NUM_COLS*NUM_ROWS-1:0] pull_dn
);
    // A key pulls its row low only while its column is driven.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            assign pull_dn[c*NUM_ROWS + r] = col_sel[c] & key_state[c*NUM_ROWS + r];
        end
    end
endmodule

// File: rtl/kbd_row_sense.sv
module kbd_row_sense #(
    parameter int NUM_COLS = 8,
    parameter int NUM_ROWS = 8
) (
    input  logic [NUM_COLS*NUM_ROWS-1:0] pull_dn,
    output logic [NUM_ROWS-1:0]          row_pressed
);
    logic [NUM_ROWS-1:0] row_line_n;

    // Each row idles high through a pull-up; any pulling key forces it low.
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        always_comb begin
            row_line_n[r] = 1'b1;
            for (int c = 0; c < NUM_COLS; c++) begin
                row_line_n[r] = row_line_n[r] & ~pull_dn[c*NUM_ROWS + r];
            end
        end
    end

    // The port reads the lines inverted, so a pressed key reads as 1.
    assign row_pressed = ~row_line_n;
endmodule

// File: rtl/kbd_access_fsm.sv
module kbd_access_fsm
    import kbd_pkg::*;
#(
    parameter int NUM_ROWS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                access_hit,
    input  logic [NUM_ROWS-1:0] scan_rows,
    output logic [NUM_ROWS-1:0] rd_data,
    output logic                rd_oe
);
    kbd_acc_state_e state_q, state_nx;
    logic [NUM_ROWS-1:0] data_q;

    // Next-state logic (GO_ACTIVE, STAY_ACTIVE, GO_IDLE).
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (access_hit)  state_nx = ST_ACTIVE;
            ST_ACTIVE: if (!access_hit) state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Output register: data is loaded only when entering or staying active.
    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (state_nx == ST_ACTIVE) data_q <= scan_rows;
        else                            data_q <= '0;
    end

    assign rd_data = data_q;
    assign rd_oe   = (state_q == ST_ACTIVE);
endmodule

// File: rtl/kbd_scan_port.sv
module kbd_scan_port
    import kbd_pkg::*;
#(
    parameter int ADDR_W   = KBD_ADDR_W,
    parameter int NUM_COLS = KBD_COLS,
    parameter int NUM_ROWS = KBD_ROWS,
    parameter int WIN_BITS = KBD_WIN_BITS,
    parameter logic [ADDR_W-1:0] WIN_BASE = KBD_WIN_BASE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic                         cpu_rd,
    input  logic                         kbd_cs,
    input  logic [NUM_COLS*NUM_ROWS-1:0] key_state,
    output logic [NUM_ROWS-1:0]          rd_data,
    output logic                         rd_oe
);
    localparam int NKEYS = NUM_COLS * NUM_ROWS;

    logic                access_hit;
    logic [NKEYS-1:0]    pull_dn;
    logic [NUM_ROWS-1:0] scan_rows;

    // Window decode on the upper address bits.
    assign access_hit = kbd_cs & cpu_rd &
                        (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    // Address bits between the column field and the window tag are ignored.
    if (WIN_BITS > NUM_COLS) begin : g_gap
        logic unused_gap_bits;
        assign unused_gap_bits = ^cpu_addr[WIN_BITS-1:NUM_COLS];
    end

    kbd_col_driver #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_cols (
        .col_sel   (cpu_addr[NUM_COLS-1:0]),
        .key_state (key_state),
        .pull_dn   (pull_dn)
    );

    kbd_row_sense #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_rows (
        .pull_dn     (pull_dn),
        .row_pressed (scan_rows)
    );

    kbd_access_fsm #(.NUM_ROWS(NUM_ROWS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .access_hit (access_hit),
        .scan_rows  (scan_rows),
        .rd_data    (rd_data),
        .rd_oe      (rd_oe)
    );
endmodule

// File: rtl/kbd_scan_port_chk.sv
module kbd_scan_port_chk
    import kbd_pkg::*;
#(
    parameter int ADDR_W   = KBD_ADDR_W,
    parameter int NUM_COLS = KBD_COLS,
    parameter int NUM_ROWS = KBD_ROWS,
    parameter int WIN_BITS = KBD_WIN_BITS,
    parameter logic [ADDR_W-1:0] WIN_BASE = KBD_WIN_BASE
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            cpu_addr,
    input logic                         cpu_rd,
    input logic                         kbd_cs,
    input logic [NUM_COLS*NUM_ROWS-1:0] key_state,
    input logic [NUM_ROWS-1:0]          rd_data,
    input logic                         rd_oe
);
    logic qual;
    assign qual = kbd_cs && cpu_rd &&
                  (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    a_r2_enable_rises: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> rd_oe);

    a_r3_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> (!rd_oe && rd_data == '0));

    a_r6_no_column_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && cpu_addr[NUM_COLS-1:0] == '0) |=> (rd_data == '0));

    a_r5_idle_matrix_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && key_state == '0) |=> (rd_data == '0));

    a_r1_data_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != '0) |-> rd_oe);
endmodule

bind kbd_scan_port kbd_scan_port_chk #(
    .ADDR_W(ADDR_W), .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS),
    .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .kbd_cs(kbd_cs), .key_state(key_state), .rd_data(rd_data), .rd_oe(rd_oe)
);

// File: tb/tb_kbd_scan_port.sv
`timescale 1ns/100ps
module tb_kbd_scan_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        kbd_cs = 1'b0;
    logic [63:0] key_state = '0;
    logic [7:0]  rd_data;
    logic        rd_oe;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    kbd_scan_port dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .kbd_cs(kbd_cs), .key_state(key_state), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    // Behavioural reference: what the port should show after one edge.
    function automatic logic [8:0] model(input logic [15:0] a, input logic rd,
                                         input logic cs, input logic [63:0] k);
        logic [7:0] d;
        bit hit;
        hit = cs && rd && (a >= 16'hF400) && (a <= 16'hF7FF);
        d = '0;
        if (hit) begin
            for (int col = 0; col < 8; col++)
                for (int row = 0; row < 8; row++)
                    if (a[col] && k[col*8 + row]) d[row] = 1'b1;
        end
        return {hit, d};
    endfunction

    task automatic compare(input string req, input logic [8:0] exp);
        checks++;
        if ({rd_oe, rd_data} !== exp) begin
            failures++;
            $display("FAIL %s: got oe=%0b data=%02h expected oe=%0b data=%02h",
                     req, rd_oe, rd_data, exp[8], exp[7:0]);
        end
    endtask

    // Apply inputs for one clock, then compare against the model.
    task automatic step(input string req, input logic [15:0] a, input logic rd,
                        input logic cs, input logic [63:0] k);
        logic [8:0] exp;
        cpu_addr = a; cpu_rd = rd; kbd_cs = cs; key_state = k;
        exp = model(a, rd, cs, k);
        @(posedge clk);
        #1;
        compare(req, exp);
    endtask

    function automatic logic [63:0] key(input int col, input int row);
        logic [63:0] v;
        v = '0;
        v[col*8 + row] = 1'b1;
        return v;
    endfunction

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] keys;
        // R1: outputs quiet in reset and just after.
        repeat (3) @(posedge clk);
        #1;
        compare("R1 in reset", 9'h000);
        rst_n = 1'b1;
        step("R1 after release", 16'h0000, 1'b0, 1'b0, '0);

        // R4: each column alone, a single key on a varying row.
        for (int c = 0; c < 8; c++) begin
            keys = key(c, (c * 3) % 8) | key((c + 1) % 8, 2);
            step("R4 single column", 16'hF400 | (16'h1 << c), 1'b1, 1'b1, keys);
            step("R3 gap between reads", 16'hF400, 1'b0, 1'b0, keys);
        end

        // R4: a pressed key in an undriven column is not seen.
        step("R4 undriven column", 16'hF401, 1'b1, 1'b1, key(5, 6));

        // R5: several columns OR together.
        keys = key(0, 1) | key(3, 4) | key(7, 7) | key(6, 0);
        step("R5 two columns", 16'hF409, 1'b1, 1'b1, keys);
        step("R5 all columns", 16'hF4FF, 1'b1, 1'b1, keys);
        step("R5 same row two cols", 16'hF403, 1'b1, 1'b1, key(0, 5) | key(1, 5));

        // R6: no column bits set.
        step("R6 no column", 16'hF400, 1'b1, 1'b1, '1);
        step("R6 no column gap bits", 16'hF700, 1'b1, 1'b1, '1);

        // R7: bits 9:8 do not matter.
        for (int g = 0; g < 4; g++)
            step("R7 gap bits", 16'hF424 | (g[15:0] << 8), 1'b1, 1'b1, keys | key(2, 3) | key(5, 2));

        // R3: outside window, or missing strobe/select.
        step("R3 below window", 16'hF3FF, 1'b1, 1'b1, '1);
        step("R3 above window", 16'hF801, 1'b1, 1'b1, '1);
        step("R3 no select", 16'hF4FF, 1'b1, 1'b0, '1);
        step("R3 no read", 16'hF4FF, 1'b0, 1'b1, '1);
        step("R2 window top", 16'hF7FF, 1'b1, 1'b1, key(7, 0));

        // R8: sustained access tracks address and keys cycle by cycle.
        for (int i = 0; i < 24; i++) begin
            keys = {8{8'(i * 37 + 5)}} ^ (64'h0123_4567_89AB_CDEF << i);
            step("R8 tracking", 16'hF400 | 16'(8'(i * 29 + 1)), 1'b1, 1'b1, keys);
        end
        step("R3 end of access", 16'hF4FF, 1'b0, 1'b0, '1);

        // R1: reset mid-access clears the outputs.
        step("R2 before reset", 16'hF4FF, 1'b1, 1'b1, '1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        compare("R1 reset mid access", 9'h000);
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule